// File: doc/BRIEF.md
# Multi-Wavefront Merged Sum-of-Products Array

This block computes the dot product of a set of unsigned operand pairs in one cycle of pure combinational logic. It adds `NUM_PAIRS` products of `OP_W`-bit values with a single merged carry-save array, not one multiplier per pair followed by an adder tree. It suits filter taps, correlators and convolution windows, where several products are always summed at once and the individual products are never needed.

The array is a square grid of unit blocks. Grid row `i` takes multiplier bit `i` of every pair, and grid column `j` takes multiplicand bit `j`, so the block at (row i, column j) has weight 2^(i+j). Each unit block is a chain of `NUM_PAIRS` full adders linked by their sum outputs. The carry of adder `v` moves diagonally to adder `v` of the block one row down and one weight up. The last sum of a block feeds the last adder of the block below it at the same weight.

Because of this structure, `NUM_PAIRS` carry wavefronts run down the grid together instead of one after another. The low `OP_W` result bits leave the grid edge already final. The bottom row is merged by a carry-save column stage into two vectors. A parallel-prefix adder covers only the remaining high bits. `NUM_PAIRS` must be at least 2.

Top module: `mwf_sum_of_products`

## Requirements
- R1: `result` equals the sum over k of `a_bus[k*OP_W +: OP_W]` times `b_bus[k*OP_W +: OP_W]`, both taken as unsigned, with pair k in bits k*OP_W upward of each bus.
- R2: `RES_W` is the number of bits needed to hold NUM_PAIRS*(2^OP_W-1)^2. With every operand bit set, `result` equals exactly that value, with nothing dropped.
- R3: The block holds no state. A change on either operand bus reaches `result` in the same cycle, without any clock edge.
- R4: `result[0]` equals the XOR over k of bit 0 of pair k's A times bit 0 of pair k's B.
- R5: When every A operand is zero, or every B operand is zero, `result` is zero whatever the other bus holds.
- R6: When only pair k is non-zero, `result` equals that pair's product for each k, including pairs whose bits enter the middle of a unit block's adder chain.
- R7: For a single pair holding 2^p and 2^q, `result` has exactly bit p+q set. Two identical such pairs give 2^(p+q+1).
- R8: Results on either side of the boundary between the edge-taken low bits and the adder-resolved high bits are exact: 2^OP_W-1 and 2^OP_W, and likewise the maximum low field combined with a high carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_bus | input | NUM_PAIRS*OP_W | Multiplicands, pair k in bits k*OP_W upward |
| b_bus | input | NUM_PAIRS*OP_W | Multipliers, pair k in bits k*OP_W upward |
| result | output | RES_W | Unsigned sum of the pair products |

## Verification
Every result is due in the cycle its operands are applied, because no register lies between the buses and `result`. The bench changes operands just after a rising edge and compares at the next falling edge, so half a period of settling separates drive and sample. For R3, one check changes an operand between edges and compares a single time unit later, with no edge in between. The full operand space of a two-pair four-bit instance is swept. Wider two-pair and three-pair instances take random operands plus the directed corner values.

// File: rtl/mwf_pkg.sv
package mwf_pkg;

  // Bits needed to hold the largest possible sum of products.
  function automatic int unsigned res_width(input int unsigned pairs,
                                            input int unsigned op_w);
    longint unsigned op_max;
    longint unsigned peak;
    op_max = (64'd1 << op_w) - 64'd1;
    peak   = op_max * op_max * longint'(pairs);
    return $clog2(peak + 64'd1);
  endfunction

endpackage

// File: rtl/mwf_full_adder.sv
module mwf_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/mwf_unit_block.sv
// One grid cell: a chain of PAIRS full adders linked by sum outputs.
// Adder 0 takes two partial-product bits, middle adders take one,
// the last adder takes the sum of the matching block in the row above.
module mwf_unit_block #(
  parameter int unsigned PAIRS = 2
) (
  input  logic [PAIRS-1:0] pp,
  input  logic [PAIRS-1:0] diag_cin,
  input  logic             sum_above,
  output logic [PAIRS-1:0] diag_cout,
  output logic             sum_last
);
  logic [PAIRS-1:0] chain_s;

  for (genvar v = 0; v < PAIRS; v++) begin : g_adder
    if (v == 0) begin : g_head
      mwf_full_adder u_fa (
        .a (pp[0]), .b (pp[1]), .ci (diag_cin[0]),
        .s (chain_s[0]), .co (diag_cout[0])
      );
    end else if (v < PAIRS - 1) begin : g_mid
      mwf_full_adder u_fa (
        .a (chain_s[v-1]), .b (pp[v+1]), .ci (diag_cin[v]),
        .s (chain_s[v]), .co (diag_cout[v])
      );
    end else begin : g_tail
      mwf_full_adder u_fa (
        .a (chain_s[v-1]), .b (diag_cin[v]), .ci (sum_above),
        .s (chain_s[v]), .co (diag_cout[v])
      );
    end
  end

  assign sum_last = chain_s[PAIRS-1];
endmodule

// File: rtl/mwf_column_merge.sv
// Reduces the PAIRS+1 bottom-row vectors (one per carry wavefront plus
// the tail sums) to two vectors with a chain of 3:2 carry-save rows.
module mwf_column_merge #(
  parameter int unsigned PAIRS = 2,
  parameter int unsigned OP_W  = 8,
  parameter int unsigned HI_W  = 9
) (
  input  logic [OP_W-1:0][PAIRS-1:0] bot_carry,
  input  logic [OP_W-1:0]            bot_sum,
  output logic [HI_W-1:0]            vec_s,
  output logic [HI_W-1:0]            vec_c
);
  logic [PAIRS:0][HI_W-1:0]   wave;
  logic [PAIRS-1:0][HI_W-1:0] acc_s;
  logic [PAIRS-1:0][HI_W-1:0] acc_c;
  logic [PAIRS-1:0][HI_W-1:0] maj;

  always_comb begin
    wave = '0;
    for (int j = 0; j < int'(OP_W); j++) begin
      for (int v = 0; v < int'(PAIRS); v++) begin
        wave[v][j] = bot_carry[j][v];
      end
      wave[PAIRS][j] = bot_sum[j];
    end
  end

  assign acc_s[0] = wave[0];
  assign acc_c[0] = wave[1];
  assign maj[0]   = '0;

  for (genvar t = 1; t < PAIRS; t++) begin : g_row
    for (genvar b = 0; b < HI_W; b++) begin : g_bit
      mwf_full_adder u_fa (
        .a (acc_s[t-1][b]), .b (acc_c[t-1][b]), .ci (wave[t+1][b]),
        .s (acc_s[t][b]), .co (maj[t][b])
      );
    end
    if (HI_W > 1) begin : g_shift
      assign acc_c[t] = {maj[t][HI_W-2:0], 1'b0};
    end else begin : g_noshift
      assign acc_c[t] = '0;
    end
    logic unused_top;
    assign unused_top = maj[t][HI_W-1];
  end

  logic unused_seed;
  assign unused_seed = ^maj[0];

  assign vec_s = acc_s[PAIRS-1];
  assign vec_c = acc_c[PAIRS-1];
endmodule

// File: rtl/mwf_prefix_adder.sv
// Parallel-prefix (log-depth) adder, carry-in zero, result modulo 2^W.
module mwf_prefix_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  localparam int unsigned LV = (W > 1) ? $clog2(W) : 1;

  logic [LV:0][W-1:0] gen_t;
  logic [LV:0][W-1:0] prp_t;

  assign gen_t[0] = x & y;
  assign prp_t[0] = x ^ y;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int unsigned D = 1 << l;
    for (genvar b = 0; b < W; b++) begin : g_bit
      if (b >= D) begin : g_comb
        assign gen_t[l+1][b] = gen_t[l][b] | (prp_t[l][b] & gen_t[l][b-D]);
        assign prp_t[l+1][b] = prp_t[l][b] & prp_t[l][b-D];
      end else begin : g_pass
        assign gen_t[l+1][b] = gen_t[l][b];
        assign prp_t[l+1][b] = prp_t[l][b];
      end
    end
  end

  assign sum[0] = prp_t[0][0];
  for (genvar b = 1; b < W; b++) begin : g_sum
    assign sum[b] = prp_t[0][b] ^ gen_t[LV][b-1];
  end

  logic unused_tail;
  assign unused_tail = gen_t[LV][W-1] ^ (^prp_t[LV]);
endmodule

// File: rtl/mwf_sum_of_products.sv
module mwf_sum_of_products
  import mwf_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned OP_W      = 8,
  parameter int unsigned RES_W     = res_width(NUM_PAIRS, OP_W)
) (
  input  logic [NUM_PAIRS*OP_W-1:0] a_bus,
  input  logic [NUM_PAIRS*OP_W-1:0] b_bus,
  output logic [RES_W-1:0]          result
);
  localparam int unsigned HI_W = RES_W - OP_W;

  // Grid indexed by (row i = multiplier bit, offset j = multiplicand bit);
  // the block at (i, j) carries weight 2^(i+j).
  logic [OP_W-1:0][OP_W-1:0][NUM_PAIRS-1:0] cout_g;
  logic [OP_W-1:0][OP_W-1:0]                slast_g;

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    for (genvar j = 0; j < OP_W; j++) begin : g_col
      logic [NUM_PAIRS-1:0] pp;
      logic [NUM_PAIRS-1:0] cin;
      logic                 s_up;

      for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pp
        assign pp[k] = a_bus[k*OP_W + j] & b_bus[k*OP_W + i];
      end

      // Diagonal source: same offset j in the previous row, one weight lower.
      if (i == 0) begin : g_top
        assign cin = '0;
      end else begin : g_inner
        assign cin = cout_g[i-1][j];
      end

      // Vertical source: previous row at equal weight, i.e. offset j+1.
      if (i == 0 || j == OP_W - 1) begin : g_no_up
        assign s_up = 1'b0;
      end else begin : g_up
        assign s_up = slast_g[i-1][j+1];
      end

      mwf_unit_block #(.PAIRS(NUM_PAIRS)) u_blk (
        .pp        (pp),
        .diag_cin  (cin),
        .sum_above (s_up),
        .diag_cout (cout_g[i][j]),
        .sum_last  (slast_g[i][j])
      );
    end
  end

  // Low bits exit the left edge of the grid already final.
  for (genvar i = 0; i < OP_W; i++) begin : g_low
    assign result[i] = slast_g[i][0];
  end

  // Bottom row: carries at weight OP_W+j, tail sums shifted down one offset.
  logic [OP_W-1:0] bot_sum;
  for (genvar j = 0; j < OP_W; j++) begin : g_bot
    if (j < OP_W - 1) begin : g_have
      assign bot_sum[j] = slast_g[OP_W-1][j+1];
    end else begin : g_none
      assign bot_sum[j] = 1'b0;
    end
  end

  logic [HI_W-1:0] vec_s;
  logic [HI_W-1:0] vec_c;
  logic [HI_W-1:0] hi_sum;

  mwf_column_merge #(
    .PAIRS (NUM_PAIRS),
    .OP_W  (OP_W),
    .HI_W  (HI_W)
  ) u_merge (
    .bot_carry (cout_g[OP_W-1]),
    .bot_sum   (bot_sum),
    .vec_s     (vec_s),
    .vec_c     (vec_c)
  );

  mwf_prefix_adder #(.W(HI_W)) u_final (
    .x   (vec_s),
    .y   (vec_c),
    .sum (hi_sum)
  );

  assign result[RES_W-1:OP_W] = hi_sum;
endmodule

// File: rtl/mwf_sum_of_products_chk.sv
module mwf_sum_of_products_chk #(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned OP_W      = 8,
  parameter int unsigned RES_W     = 17
) (
  input logic [NUM_PAIRS*OP_W-1:0] a_bus,
  input logic [NUM_PAIRS*OP_W-1:0] b_bus,
  input logic [RES_W-1:0]          result
);
  longint unsigned ref_sum;
  longint unsigned peak;
  logic            bit0_ref;

  always_comb begin
    ref_sum  = 0;
    bit0_ref = 1'b0;
    for (int k = 0; k < int'(NUM_PAIRS); k++) begin
      ref_sum  = ref_sum + longint'(a_bus[k*OP_W +: OP_W]) * longint'(b_bus[k*OP_W +: OP_W]);
      bit0_ref = bit0_ref ^ (a_bus[k*OP_W] & b_bus[k*OP_W]);
    end
    peak = longint'(NUM_PAIRS) * ((64'd1 << OP_W) - 64'd1) * ((64'd1 << OP_W) - 64'd1);
  end

  always_comb begin
    if (!$isunknown({a_bus, b_bus, result})) begin
      p_exact_sum_r1 : assert (longint'(result) == ref_sum)
        else $error("R1 result %0d expected %0d", result, ref_sum);
      p_in_range_r2 : assert (longint'(result) <= peak)
        else $error("R2 result %0d above %0d", result, peak);
      p_low_bit_r4 : assert (result[0] == bit0_ref)
        else $error("R4 bit 0 mismatch");
      p_zero_a_r5 : assert (!(a_bus == '0) || result == '0)
        else $error("R5 zero A gave %0d", result);
      p_zero_b_r5 : assert (!(b_bus == '0) || result == '0)
        else $error("R5 zero B gave %0d", result);
    end
  end
endmodule

bind mwf_sum_of_products mwf_sum_of_products_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .OP_W      (OP_W),
  .RES_W     (RES_W)
) u_chk (
  .a_bus  (a_bus),
  .b_bus  (b_bus),
  .result (result)
);

// File: tb/mwf_sum_of_products_bench.sv
module mwf_sum_of_products_bench;
  import mwf_pkg::*;

  localparam int unsigned M0 = 2, N0 = 4;
  localparam int unsigned M1 = 2, N1 = 8;
  localparam int unsigned M2 = 3, N2 = 6;
  localparam int unsigned R0 = res_width(M0, N0);
  localparam int unsigned R1W = res_width(M1, N1);
  localparam int unsigned R2W = res_width(M2, N2);

  // 10-unit period: 100 MHz with 1 ns units.
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic [M0*N0-1:0] a0, b0;
  logic [R0-1:0]    r0;
  logic [M1*N1-1:0] a1, b1;
  logic [R1W-1:0]   r1;
  logic [M2*N2-1:0] a2, b2;
  logic [R2W-1:0]   r2;

  mwf_sum_of_products #(.NUM_PAIRS(M0), .OP_W(N0)) u_mwf_sum_of_products (
    .a_bus(a0), .b_bus(b0), .result(r0));
  mwf_sum_of_products #(.NUM_PAIRS(M1), .OP_W(N1)) u_mwf_sum_of_products_w8 (
    .a_bus(a1), .b_bus(b1), .result(r1));
  mwf_sum_of_products #(.NUM_PAIRS(M2), .OP_W(N2)) u_mwf_sum_of_products_m3 (
    .a_bus(a2), .b_bus(b2), .result(r2));

  int n_cmp = 0;
  int n_bad = 0;

  function automatic longint unsigned sop(input logic [63:0] a, input logic [63:0] b,
                                          input int m, input int n);
    longint unsigned acc = 0;
    longint unsigned mask = (64'd1 << n) - 64'd1;
    for (int k = 0; k < m; k++) begin
      acc += ((a >> (k*n)) & mask) * ((b >> (k*n)) & mask);
    end
    return acc;
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step_in;
    @(posedge clk);
  endtask

  task automatic step_out;
    @(negedge clk);
  endtask

  initial begin
    #(190000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0;
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step_out();
    // Quiescent state with all-zero operands (R5).
    chk("R5 idle w4", r0, 0);
    chk("R5 idle w8", r1, 0);
    chk("R5 idle m3", r2, 0);

    // R5: one bus all ones, the other zero.
    step_in(); a1 = '1; b1 = '0; a2 = '0; b2 = '1;
    step_out();
    chk("R5 B zero", r1, 0);
    chk("R5 A zero", r2, 0);

    // R2: every operand bit set.
    step_in(); a0 = '1; b0 = '1; a1 = '1; b1 = '1; a2 = '1; b2 = '1;
    step_out();
    chk("R2 max w4", r0, M0 * ((64'd1 << N0) - 1) ** 2);
    chk("R2 max w8", r1, M1 * ((64'd1 << N1) - 1) ** 2);
    chk("R2 max m3", r2, M2 * ((64'd1 << N2) - 1) ** 2);

    // R3: change between edges and look one unit later.
    step_in(); a1 = 16'h0307; b1 = 16'h0205;
    step_out();
    chk("R3 settle", r1, 41);
    #1 a1 = 16'h0409;
    #1 chk("R3 no edge", r1, 53);

    // R8: around the low/high split.
    step_in(); a1 = {8'd0, 8'd255}; b1 = {8'd0, 8'd1};
    step_out();
    chk("R8 below split", r1, 255);
    step_in(); a1 = {8'd1, 8'd255}; b1 = {8'd1, 8'd1};
    step_out();
    chk("R8 at split", r1, 256);
    step_in(); a1 = {8'd255, 8'd255}; b1 = {8'd1, 8'd2};
    step_out();
    chk("R8 low max with carry", r1, 765);

    // R7: single-bit operands across every grid column.
    for (int p = 0; p < int'(N1); p++) begin
      for (int q = 0; q < int'(N1); q++) begin
        step_in();
        a1 = '0; b1 = '0;
        a1[p] = 1'b1; b1[q] = 1'b1;
        step_out();
        chk("R7 one pair", r1, 64'd1 << (p + q));
        step_in();
        a1[N1 + p] = 1'b1; b1[N1 + q] = 1'b1;
        step_out();
        chk("R7 two pairs", r1, 64'd2 << (p + q));
      end
    end

    // R6: one active pair at a time, each lane of the three-pair array.
    for (int k = 0; k < int'(M2); k++) begin
      for (int t = 0; t < 40; t++) begin
        logic [N2-1:0] x;
        logic [N2-1:0] y;
        x = N2'($urandom);
        y = N2'($urandom);
        if (t == 0) begin x = '1; y = '1; end
        step_in();
        a2 = '0; b2 = '0;
        a2[k*N2 +: N2] = x;
        b2[k*N2 +: N2] = y;
        step_out();
        chk("R6 lone pair", r2, longint'(x) * longint'(y));
      end
    end

    // R1: exhaustive over the two-pair four-bit instance.
    for (int v = 0; v < 65536; v++) begin
      step_in();
      a0 = v[7:0];
      b0 = v[15:8];
      step_out();
      chk("R1 sweep w4", r0, sop(a0, b0, M0, N0));
    end

    // R1 and R4: random operands on the wider instances.
    for (int t = 0; t < 3000; t++) begin
      step_in();
      a1 = 16'($urandom); b1 = 16'($urandom);
      a2 = 18'($urandom); b2 = 18'($urandom);
      step_out();
      chk("R1 random w8", r1, sop(a1, b1, M1, N1));
      chk("R1 random m3", r2, sop(a2, b2, M2, N2));
      if (t < 200) begin
        chk("R4 bit0", r1[0], (a1[0] & b1[0]) ^ (a1[N1] & b1[N1]));
      end
    end

    wrap_up();
  end
endmodule